// File: doc/BRIEF.md
# Pin-Sampled I2C Target Decoder

This block turns two software-driven pin levels, a data line and a clock line, into I2C target behaviour. The levels are sampled once per system clock. Each step of the bus protocol is recognised only from a change between two consecutive samples, so the block needs no bus clock of its own. A start condition arms the decoder. The first byte after a start is the address, and its lowest bit selects the direction. Every later byte is either received and passed on, or fetched from a register backend and shifted out, most significant bit first.

The block also produces the data level the target presents back to the controller. That level is the acknowledge on each received byte and the data bits of each transmitted byte. Software that reads the data pin combines this level with its own. The backend sees three things: a start event that carries the address, an end event, and two byte channels. Received bytes leave on a valid/ready channel. Bytes to transmit come in on a valid/ready channel that the decoder accepts in a single cycle.

The bus cannot be held back, because the block does not stretch the clock. On the outgoing channel, `wr_valid_o` stays high until `wr_ready_i` is seen. A byte that is still waiting when the next byte completes is replaced by the newer one. On the incoming channel, `rd_ready_o` is high for exactly one cycle each time a byte is needed. The byte is taken in that cycle if `rd_valid_i` is high. Otherwise the decoder transmits all ones, which is the idle level of the line.

Top module: `swpin_i2c_target`

## Requirements
- R1: After reset `sda_o` is 1, `wr_valid_o` is 0, and no start, end or fetch pulse appears while both lines stay high.
- R2: A start condition arms the decoder. A start is the data line falling while the clock line is high. The decoder then reads the following address byte MSB first, one bit on each clock fall. It then gives one `xfer_start_o` pulse with `xfer_addr_o` equal to the address with bit 0 forced to 0, and with `xfer_rd_o` equal to address bit 0.
- R3: While the bits of a received byte are on the bus, `sda_o` is 1. After the eighth bit's clock fall, `sda_o` is 0 (acknowledge) until the next clock fall.
- R4: When the address bit 0 is 0, each byte after the address is presented once on `wr_data_o`, in bus order. The address byte itself never appears on this channel.
- R5: `wr_valid_o` and `wr_data_o` hold steady while `wr_ready_i` is 0. A byte that completes while an earlier one is still pending replaces it.
- R6: When the address bit 0 is 1, `rd_ready_o` pulses once on the clock fall that ends the address acknowledge. The fetched byte is then driven on `sda_o` MSB first, one bit per clock period. `sda_o` is 1 during the ninth slot.
- R7: A fetch made while `rd_valid_i` is 0 transmits the byte 0xFF.
- R8: The clock fall that ends each ninth slot of a read fetches and transmits a further byte, whatever level the controller drove in that slot.
- R9: A stop condition in any non-idle state returns the decoder to idle. A stop is the data line rising while the clock line is high. If an address had been latched, the stop gives exactly one `xfer_end_o` pulse.
- R10: A stop that arrives before the address byte is complete gives no `xfer_end_o` and no `xfer_start_o`, and a later full transaction is decoded normally.
- R11: Data line changes while the clock line is low never count as start or stop. Without a start, clock pulses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sda_i | input | 1 | Sampled data line level driven by the controller |
| scl_i | input | 1 | Sampled clock line level driven by the controller |
| sda_o | output | 1 | Data level presented by the target (0 = pull low) |
| xfer_start_o | output | 1 | One-cycle pulse when an address byte has been taken |
| xfer_addr_o | output | BYTE_W | Latched address with bit 0 forced to 0 |
| xfer_rd_o | output | 1 | Direction of the current transfer, 1 = read |
| xfer_end_o | output | 1 | One-cycle pulse on a stop after an address |
| wr_valid_o | output | 1 | Received byte available |
| wr_data_o | output | BYTE_W | Received byte |
| wr_ready_i | input | 1 | Backend accepts the received byte |
| rd_ready_o | output | 1 | Decoder takes a byte to transmit this cycle |
| rd_valid_i | input | 1 | Backend has a byte to transmit |
| rd_data_i | input | BYTE_W | Byte to transmit |

## Verification
Directed write transactions use bytes with alternating, all-zero and all-one bit patterns. These separate a wrong bit order from a wrong acknowledge position, and they exercise many data-line changes while the clock is low. Directed reads cover three cases: a positive acknowledge, a negative acknowledge, and a backend that is not ready. These distinguish the fetch points and the 0xFF fill from plain shift errors. A stop in the middle of an address and a period of pin wiggling without a start check the edge qualification. A seeded random mix of read and write transactions, with random addresses and lengths, is compared against byte lists computed in the bench.

// File: rtl/i2cbb_pkg.sv
package i2cbb_pkg;
  typedef enum logic [2:0] {
    BB_IDLE,
    BB_ARMED,
    BB_SHIFT_IN,
    BB_ACK_IN,
    BB_SHIFT_OUT,
    BB_ACK_OUT
  } bb_state_e;
endpackage

// File: rtl/pin_edge_detect.sv
module pin_edge_detect #(
  parameter int unsigned LINES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lvl_i,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);
  logic [LINES-1:0] prev_q;

  // previous levels start released so no false stop can appear after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= lvl_i;
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
    assign fall_o[g] = ~lvl_i[g] & prev_q[g];
  end
endmodule

// File: rtl/byte_out_stage.sv
module byte_out_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  output logic         m_valid_o,
  output logic [W-1:0] m_data_o,
  input  logic         m_ready_i
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid_o <= 1'b0;
      m_data_o  <= '0;
    end else if (push_i) begin
      m_valid_o <= 1'b1;
      m_data_o  <= push_data_i;
    end else if (m_valid_o && m_ready_i) begin
      m_valid_o <= 1'b0;
    end
  end

  // R5
  hold_under_bp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid_o && !m_ready_i && !push_i) |=> (m_valid_o && $stable(m_data_o)));
endmodule

// File: rtl/bb_i2c_fsm.sv
module bb_i2c_fsm
  import i2cbb_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_i,
  input  logic              scl_i,
  input  logic              sda_rise_i,
  input  logic              sda_fall_i,
  input  logic              scl_fall_i,
  output logic              sda_drive_o,
  output logic              push_o,
  output logic [BYTE_W-1:0] push_data_o,
  output logic              xfer_start_o,
  output logic              xfer_end_o,
  output logic [BYTE_W-1:0] xfer_addr_o,
  output logic              xfer_rd_o,
  output logic              rd_ready_o,
  input  logic              rd_valid_i,
  input  logic [BYTE_W-1:0] rd_data_i
);
  localparam int unsigned CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  bb_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [BYTE_W-1:0] addr_q;
  logic              addr_vld_q;
  logic              start_q;
  logic              end_q;

  logic start_cond, stop_cond, active, rd_dir, fetch;
  logic [BYTE_W-1:0] fetched;

  assign start_cond = sda_fall_i & scl_i;
  assign stop_cond  = sda_rise_i & scl_i;
  assign active     = (state_q != BB_IDLE);
  // before the address is latched the direction is the bit just received
  assign rd_dir     = addr_vld_q ? addr_q[0] : shreg_q[0];
  assign fetch      = scl_fall_i &&
                      ((state_q == BB_ACK_IN && rd_dir) || state_q == BB_ACK_OUT);
  assign fetched    = rd_valid_i ? rd_data_i : '1;

  assign rd_ready_o  = fetch;
  assign push_o      = scl_fall_i && state_q == BB_ACK_IN && addr_vld_q;
  assign push_data_o = shreg_q;

  always_comb begin
    unique case (state_q)
      BB_ACK_IN:    sda_drive_o = 1'b0;
      BB_SHIFT_OUT: sda_drive_o = shreg_q[BYTE_W-1];
      default:      sda_drive_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= BB_IDLE;
      cnt_q      <= '0;
      shreg_q    <= '0;
      addr_q     <= '0;
      addr_vld_q <= 1'b0;
      start_q    <= 1'b0;
      end_q      <= 1'b0;
    end else begin
      start_q <= 1'b0;
      end_q   <= 1'b0;
      if (active && stop_cond) begin
        state_q    <= BB_IDLE;
        addr_vld_q <= 1'b0;
        end_q      <= addr_vld_q;
      end else begin
        unique case (state_q)
          BB_IDLE: begin
            if (start_cond) state_q <= BB_ARMED;
          end
          BB_ARMED: begin
            if (scl_fall_i && !sda_i) begin
              state_q <= BB_SHIFT_IN;
              cnt_q   <= LAST_BIT;
            end
          end
          BB_SHIFT_IN: begin
            if (scl_fall_i) begin
              shreg_q <= {shreg_q[BYTE_W-2:0], sda_i};
              if (cnt_q == '0) state_q <= BB_ACK_IN;
              else             cnt_q   <= cnt_q - 1'b1;
            end
          end
          BB_ACK_IN: begin
            if (scl_fall_i) begin
              if (!addr_vld_q) begin
                addr_q     <= shreg_q;
                addr_vld_q <= 1'b1;
                start_q    <= 1'b1;
              end
              cnt_q <= LAST_BIT;
              if (rd_dir) begin
                state_q <= BB_SHIFT_OUT;
                shreg_q <= fetched;
              end else begin
                state_q <= BB_SHIFT_IN;
              end
            end
          end
          BB_SHIFT_OUT: begin
            if (scl_fall_i) begin
              shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
              if (cnt_q == '0) state_q <= BB_ACK_OUT;
              else             cnt_q   <= cnt_q - 1'b1;
            end
          end
          BB_ACK_OUT: begin
            if (scl_fall_i) begin
              state_q <= BB_SHIFT_OUT;
              shreg_q <= fetched;
              cnt_q   <= LAST_BIT;
            end
          end
          default: state_q <= BB_IDLE;
        endcase
      end
    end
  end

  assign xfer_start_o = start_q;
  assign xfer_end_o   = end_q;
  assign xfer_addr_o  = {addr_q[BYTE_W-1:1], 1'b0};
  assign xfer_rd_o    = addr_q[0];

  // R3
  ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == BB_SHIFT_IN && cnt_q == '0 && scl_fall_i) |=> (sda_drive_o == 1'b0));
  // R9
  stop_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && stop_cond) |=> (state_q == BB_IDLE));
  // R10
  end_needs_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && stop_cond && !addr_vld_q) |=> !xfer_end_o);
  // R6
  rd_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready_o |=> (state_q == BB_SHIFT_OUT && cnt_q == LAST_BIT));
  // R2
  start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start_o |=> !xfer_start_o);
endmodule

// File: rtl/swpin_i2c_target.sv
module swpin_i2c_target #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_i,
  input  logic              scl_i,
  output logic              sda_o,
  output logic              xfer_start_o,
  output logic [BYTE_W-1:0] xfer_addr_o,
  output logic              xfer_rd_o,
  output logic              xfer_end_o,
  output logic              wr_valid_o,
  output logic [BYTE_W-1:0] wr_data_o,
  input  logic              wr_ready_i,
  output logic              rd_ready_o,
  input  logic              rd_valid_i,
  input  logic [BYTE_W-1:0] rd_data_i
);
  localparam int unsigned SDA_IDX = 0;
  localparam int unsigned SCL_IDX = 1;

  logic [1:0]        rise, fall;
  logic              push;
  logic [BYTE_W-1:0] push_data;

  pin_edge_detect #(.LINES(2)) u_edges (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  ({scl_i, sda_i}),
    .rise_o (rise),
    .fall_o (fall)
  );

  bb_i2c_fsm #(.BYTE_W(BYTE_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sda_i        (sda_i),
    .scl_i        (scl_i),
    .sda_rise_i   (rise[SDA_IDX]),
    .sda_fall_i   (fall[SDA_IDX]),
    .scl_fall_i   (fall[SCL_IDX]),
    .sda_drive_o  (sda_o),
    .push_o       (push),
    .push_data_o  (push_data),
    .xfer_start_o (xfer_start_o),
    .xfer_end_o   (xfer_end_o),
    .xfer_addr_o  (xfer_addr_o),
    .xfer_rd_o    (xfer_rd_o),
    .rd_ready_o   (rd_ready_o),
    .rd_valid_i   (rd_valid_i),
    .rd_data_i    (rd_data_i)
  );

  byte_out_stage #(.W(BYTE_W)) u_wr (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push),
    .push_data_i (push_data),
    .m_valid_o   (wr_valid_o),
    .m_data_o    (wr_data_o),
    .m_ready_i   (wr_ready_i)
  );

  // R11
  no_edge_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_i && $past(!scl_i)) |=> !xfer_start_o && !xfer_end_o);
endmodule

// File: tb/swpin_i2c_target_tb_top.sv
`timescale 1ns/1ps
module swpin_i2c_target_tb_top;
  localparam int PH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sda_i = 1'b1, scl_i = 1'b1;
  logic sda_o, xfer_start_o, xfer_rd_o, xfer_end_o, wr_valid_o, rd_ready_o;
  logic [7:0] xfer_addr_o, wr_data_o;
  logic wr_ready_i = 1'b1, rd_valid_i = 1'b1;
  logic [7:0] rd_data_i = 8'h00;

  always #2.5 clk = ~clk;

  swpin_i2c_target #(.BYTE_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .sda_i(sda_i), .scl_i(scl_i), .sda_o(sda_o),
    .xfer_start_o(xfer_start_o), .xfer_addr_o(xfer_addr_o), .xfer_rd_o(xfer_rd_o),
    .xfer_end_o(xfer_end_o), .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o),
    .wr_ready_i(wr_ready_i), .rd_ready_o(rd_ready_o), .rd_valid_i(rd_valid_i),
    .rd_data_i(rd_data_i)
  );

  int errors = 0, checks = 0;
  int n_start = 0, n_end = 0, n_wr = 0, n_rd = 0;
  logic [7:0] last_addr = 8'h00;
  logic last_rd = 1'b0;
  logic [7:0] wr_log [0:63];
  bit done = 0;

  always begin
    @(negedge clk); #1;
    if (rst_n) begin
      if (xfer_start_o) begin n_start++; last_addr = xfer_addr_o; last_rd = xfer_rd_o; end
      if (xfer_end_o) n_end++;
      if (wr_valid_o && wr_ready_i) begin wr_log[n_wr % 64] = wr_data_o; n_wr++; end
      if (rd_ready_o) n_rd++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_addr(input logic [7:0] a);
    return a & 8'hFE;
  endfunction

  task automatic drive(input logic s, input logic c);
    sda_i = s; scl_i = c;
    repeat (PH) @(negedge clk);
  endtask

  task automatic bus_start();
    drive(1, 1); drive(0, 1); drive(0, 0);
  endtask

  task automatic bus_stop();
    drive(0, 0); drive(0, 1); drive(1, 1);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack, output logic relbad);
    relbad = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      drive(b[i], 0); drive(b[i], 1);
      if (sda_o !== 1'b1) relbad = 1'b1;
      drive(b[i], 0);
    end
    drive(1, 0); drive(1, 1);
    ack = sda_o;
    drive(1, 0);
  endtask

  task automatic rbyte(output logic [7:0] got, output logic slot9);
    for (int i = 7; i >= 0; i--) begin
      drive(1, 0); drive(1, 1);
      got[i] = sda_o;
      drive(1, 0);
    end
    slot9 = sda_o;
  endtask

  task automatic rack(input logic ab, input logic [7:0] nd, input logic nv);
    rd_data_i = nd; rd_valid_i = nv;
    drive(ab, 0); drive(ab, 1); drive(ab, 0);
  endtask

  task automatic do_write(input logic [7:0] addr, input logic [7:0] d [4], input int n);
    logic ack, rb;
    int s0 = n_start, e0 = n_end, w0 = n_wr;
    bus_start();
    wbyte(addr, ack, rb);
    chk(ack == 1'b0, "R3 addr ack", ack, 0);
    chk(rb == 1'b0, "R3 released during bits", rb, 0);
    for (int k = 0; k < n; k++) begin
      wbyte(d[k], ack, rb);
      chk(ack == 1'b0 && rb == 1'b0, "R3 data ack", {ack, rb}, 0);
    end
    bus_stop();
    chk(n_start == s0 + 1 && last_addr == exp_addr(addr) && last_rd == addr[0],
        "R2 start addr", last_addr, exp_addr(addr));
    chk(n_wr == w0 + n, "R4 byte count", n_wr - w0, n);
    for (int k = 0; k < n; k++)
      chk(wr_log[(w0 + k) % 64] == d[k], "R4 write data", wr_log[(w0 + k) % 64], d[k]);
    chk(n_end == e0 + 1, "R9 end pulse", n_end - e0, 1);
    chk(sda_o == 1'b1, "R9 idle released", sda_o, 1);
  endtask

  task automatic do_read(input logic [7:0] addr, input logic [7:0] d [4], input int n,
                         input logic [3:0] acks);
    logic ack, rb, s9;
    logic [7:0] got;
    int s0 = n_start, e0 = n_end, r0 = n_rd;
    rd_data_i = d[0]; rd_valid_i = 1'b1;
    bus_start();
    wbyte(addr | 8'h01, ack, rb);
    chk(ack == 1'b0, "R6 addr ack", ack, 0);
    for (int k = 0; k < n; k++) begin
      rbyte(got, s9);
      chk(got == d[k], "R6 read byte", got, d[k]);
      chk(s9 == 1'b1, "R6 ninth slot released", s9, 1);
      if (k < n - 1) rack(acks[k], d[k + 1], 1'b1);
    end
    bus_stop();
    chk(n_start == s0 + 1 && last_addr == exp_addr(addr) && last_rd == 1'b1,
        "R2 read start", last_addr, exp_addr(addr));
    chk(n_rd == r0 + n, "R8 fetch count", n_rd - r0, n);
    chk(n_end == e0 + 1, "R9 read end", n_end - e0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d [4];
    logic ack, rb, s9;
    logic [7:0] got;
    int s0, e0, w0, seed;
    seed = $urandom(32'h1C2B);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (PH) @(negedge clk);

    // R1 reset state
    chk(sda_o == 1'b1 && wr_valid_o == 1'b0, "R1 reset outputs", {sda_o, wr_valid_o}, 2);
    chk(n_start == 0 && n_end == 0 && n_rd == 0, "R1 no pulses", n_start + n_end + n_rd, 0);

    // R11 wiggling without a start
    drive(1, 0); drive(0, 0); drive(1, 0); drive(0, 0); drive(0, 1); drive(0, 0);
    drive(1, 0); drive(1, 1); drive(0, 0); drive(1, 1);
    chk(n_start == 0 && n_end == 0 && n_wr == 0 && sda_o == 1'b1, "R11 no effect",
        n_start + n_end + n_wr, 0);

    // R4 directed write with patterned bytes
    d[0] = 8'h5A; d[1] = 8'h00; d[2] = 8'hFF; d[3] = 8'hA5;
    do_write(8'hA4, d, 4);

    // R6 / R8 directed read with ack then nack
    d[0] = 8'hC3; d[1] = 8'h81; d[2] = 8'h7E; d[3] = 8'h00;
    do_read(8'h35, d, 3, 4'b0010);

    // R7 backend not ready
    rd_valid_i = 1'b0;
    bus_start();
    wbyte(8'h69, ack, rb);
    rbyte(got, s9);
    chk(got == 8'hFF, "R7 idle fill", got, 8'hFF);
    rack(1'b0, 8'h12, 1'b0);
    rbyte(got, s9);
    chk(got == 8'hFF, "R7 idle fill second", got, 8'hFF);
    bus_stop();
    rd_valid_i = 1'b1;

    // R5 back-pressure and replacement
    wr_ready_i = 1'b0;
    w0 = n_wr;
    bus_start();
    wbyte(8'h20, ack, rb);
    wbyte(8'h11, ack, rb);
    chk(wr_valid_o == 1'b1 && wr_data_o == 8'h11, "R5 pending", wr_data_o, 8'h11);
    wbyte(8'h22, ack, rb);
    repeat (20) @(negedge clk);
    chk(wr_valid_o == 1'b1 && wr_data_o == 8'h22, "R5 replaced and held", wr_data_o, 8'h22);
    bus_stop();
    wr_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(n_wr == w0 + 1 && wr_log[w0 % 64] == 8'h22, "R5 single delivery", n_wr - w0, 1);
    chk(wr_valid_o == 1'b0, "R5 drained", wr_valid_o, 0);

    // R10 stop inside the address byte
    s0 = n_start; e0 = n_end;
    bus_start();
    drive(1, 0); drive(1, 1); drive(1, 0);
    drive(0, 0); drive(0, 1); drive(0, 0);
    bus_stop();
    chk(n_start == s0 && n_end == e0, "R10 no events", n_end - e0, 0);
    d[0] = 8'h3C; d[1] = 8'h00; d[2] = 8'h00; d[3] = 8'h00;
    do_write(8'h42, d, 1);

    // random mix
    for (int t = 0; t < 24; t++) begin
      logic [7:0] a;
      int n;
      a = 8'($urandom());
      n = 1 + int'($urandom() % 4);
      for (int k = 0; k < 4; k++) d[k] = 8'($urandom());
      if ($urandom() % 2 == 0) do_write(a & 8'hFE, d, n);
      else                     do_read(a, d, n, 4'($urandom()));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule